// File: doc/BRIEF.md
# Timed Instruction Injection Sequencer

The sequencer sits between a test harness and the fetch side of a processor under test. The harness sends 64-bit packets over a valid/ready stream. Each packet holds a 32-bit instruction word, a 16-bit timestamp and an 8-bit command byte. The sequencer paces the packets so that each one takes effect a fixed number of cycles after it is accepted. That number is the difference between the packet's timestamp and the timestamp of the packet accepted before it. Pacing of this kind makes a run repeatable on hardware and still lets a software model ignore time.

When the wait ends, an instruction packet presents its word on the fetch port. The word is held there until the core accepts it, together with a flag that marks a compressed 16-bit encoding. A reset packet instead drives a reset pulse of fixed length into the core and sets the timestamp base back to zero. A packet with a command it does not know is discarded, and a sticky error flag records it. Only one packet is in flight at a time.

Top module: `inject_sequencer`

## Requirements
- R1: Packet fields are instruction word = bits 31:0, timestamp = bits 47:32 and command = bits 55:48. Bits 63:56 have no effect on any output.
- R2: `pkt_ready` is high only while no packet is in flight. A packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both high, and `pkt_ready` is low in the cycle after it is taken.
- R3: For command 0x00 (inject), `insn_valid` rises D clock edges after the accepting edge, where D = (timestamp − previous timestamp) mod 2^16. For D = 0 it is high in the cycle right after acceptance.
- R4: While `insn_valid` is high and `insn_accept` is low, `insn_valid`, `insn_word` and `insn_compressed` stay unchanged. On an edge with `insn_accept` high, `insn_valid` falls and `pkt_ready` rises.
- R5: `insn_compressed` is high exactly when bits 1:0 of the issued word are not 2'b11.
- R6: For command 0x01 (reset), `dut_reset` rises after the same wait as in R3 and stays high for exactly 4 cycles. `pkt_ready` returns in the cycle in which `dut_reset` falls. `dut_reset` and `insn_valid` are never high together.
- R7: A reset command sets the previous timestamp to 0, so the delay of the next packet equals its own timestamp.
- R8: Any other command value is dropped. It issues nothing, pulses no reset, leaves the previous timestamp unchanged and keeps `pkt_ready` high. It also sets `cmd_error`, which stays high until `rst_n` goes low.
- R9: The timestamp difference wraps: a timestamp smaller than the previous one waits 2^16 minus the backward distance.
- R10: While `rst_n` is low, on each clock edge the block goes to `pkt_ready`=1, `insn_valid`=0, `dut_reset`=0 and `cmd_error`=0, with a previous timestamp of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Harness offers a packet |
| pkt_data | input | 64 | Packet: command, timestamp, instruction |
| pkt_ready | output | 1 | Sequencer can take a packet |
| insn_valid | output | 1 | Instruction word presented to the core |
| insn_word | output | 32 | Issued instruction word |
| insn_compressed | output | 1 | Issued word is a 16-bit compressed encoding |
| insn_accept | input | 1 | Core takes the presented word |
| dut_reset | output | 1 | Active-high reset pulse to the core under test |
| cmd_error | output | 1 | Sticky flag for an unknown command |

## Verification
The accepting edge counts as edge 0. An issued word or a reset pulse is due after edge D. The drop of `insn_valid` and the return of `pkt_ready` are due one edge after the accept edge. The error flag is due one edge after acceptance. The bench drives inputs and samples outputs on falling edges. After each packet it counts falling edges from the first one after acceptance, so an event seen at count k happened after edge k, and it compares k with the expected D. The reset pulse is measured the same way, by counting the falling edges at which it is high, and stability is checked at falling edges during which the core has not yet accepted.

// File: rtl/inj_pkg.sv
// Package: shared encodings for the injection sequencer.
// Assumes an 8-bit command field; the two command codes are fixed by the stream.
package inj_pkg;
    localparam logic [7:0] CMD_INJECT = 8'h00;
    localparam logic [7:0] CMD_RESET  = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_RESET
    } seq_state_t;

    typedef enum logic [1:0] {
        ACT_INJECT,
        ACT_RESET,
        ACT_DROP
    } act_kind_t;

    // A 32-bit encoding always ends in 2'b11; anything else is compressed.
    function automatic logic is_compressed(input logic [1:0] low_bits);
        return low_bits != 2'b11;
    endfunction
endpackage

// File: rtl/inj_pkt_decode.sv
// Module: splits an incoming packet into its fields, classifies the command
// and computes the wrapping timestamp distance from the stored base.
// Assumes the field layout instruction | timestamp | command | pad, LSB first.
module inj_pkt_decode
    import inj_pkg::*;
#(
    parameter int PKT_W  = 64,
    parameter int CMD_W  = 8,
    parameter int TS_W   = 16,
    parameter int INSN_W = 32
) (
    input  logic [PKT_W-1:0]  pkt,
    input  logic [TS_W-1:0]   base_ts,
    output logic [INSN_W-1:0] insn,
    output logic [TS_W-1:0]   ts,
    output logic [TS_W-1:0]   delta,
    output act_kind_t         kind
);
    localparam int TS_LSB  = INSN_W;
    localparam int CMD_LSB = INSN_W + TS_W;

    logic [CMD_W-1:0] cmd;

    // Field extraction and modular distance.
    always_comb begin
        insn  = pkt[INSN_W-1:0];
        ts    = pkt[TS_LSB +: TS_W];
        cmd   = pkt[CMD_LSB +: CMD_W];
        delta = ts - base_ts;
    end

    // Command classification; every code other than the two known ones drops.
    always_comb begin
        if (cmd == CMD_W'(CMD_INJECT))      kind = ACT_INJECT;
        else if (cmd == CMD_W'(CMD_RESET))  kind = ACT_RESET;
        else                                kind = ACT_DROP;
    end
endmodule

// File: rtl/inj_delay_timer.sv
// Module: down-counter that times the wait before a packet takes effect.
// Assumes a load value of at least 1; "last" marks the final waiting cycle.
module inj_delay_timer #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_val,
    output logic            last
);
    logic [TS_W-1:0] cnt;

    // Load on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == TS_W'(1));

    // R3
    timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> (cnt != '0));
endmodule

// File: rtl/inj_pulse_gen.sv
// Module: produces the fixed-length reset pulse for the core under test.
// Assumes start arrives only while no pulse is running.
module inj_pulse_gen #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Arm the pulse length on start, count it down while active.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(RST_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
    assign last   = (cnt == CNT_W'(1));

    // R6
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
endmodule

// File: rtl/inject_sequencer.sv
// Module: timed instruction injection sequencer (top).
// Takes one packet at a time, waits the timestamp distance, then issues the
// word to the fetch port or pulses the core reset. Unknown commands are dropped.
// Assumes the harness holds pkt_data stable while pkt_valid is high.
module inject_sequencer
    import inj_pkg::*;
#(
    parameter int PKT_W      = 64,
    parameter int CMD_W      = 8,
    parameter int TS_W       = 16,
    parameter int INSN_W     = 32,
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic [PKT_W-1:0]  pkt_data,
    output logic              pkt_ready,
    output logic              insn_valid,
    output logic [INSN_W-1:0] insn_word,
    output logic              insn_compressed,
    input  logic              insn_accept,
    output logic              dut_reset,
    output logic              cmd_error
);
    seq_state_t        state;
    act_kind_t         pend_kind;
    act_kind_t         fire_kind;
    logic [TS_W-1:0]   base_ts;
    logic [INSN_W-1:0] dec_insn;
    logic [TS_W-1:0]   dec_ts;
    logic [TS_W-1:0]   dec_delta;
    act_kind_t         dec_kind;
    logic [INSN_W-1:0] word_q;
    logic              comp_q;
    logic              accept;
    logic              take;
    logic              fire;
    logic              tmr_load;
    logic              tmr_last;
    logic              pulse_start;
    logic              pulse_last;

    inj_pkt_decode #(
        .PKT_W (PKT_W),
        .CMD_W (CMD_W),
        .TS_W  (TS_W),
        .INSN_W(INSN_W)
    ) u_decode (
        .pkt    (pkt_data),
        .base_ts(base_ts),
        .insn   (dec_insn),
        .ts     (dec_ts),
        .delta  (dec_delta),
        .kind   (dec_kind)
    );

    inj_delay_timer #(.TS_W(TS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(dec_delta),
        .last    (tmr_last)
    );

    inj_pulse_gen #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .active(dut_reset),
        .last  (pulse_last)
    );

    // Handshake and action decisions for the current cycle.
    always_comb begin
        pkt_ready   = (state == ST_IDLE);
        accept      = pkt_valid && pkt_ready;
        take        = accept && (dec_kind != ACT_DROP);
        tmr_load    = take && (dec_delta != '0);
        fire        = (take && (dec_delta == '0)) ||
                      ((state == ST_WAIT) && tmr_last);
        fire_kind   = (state == ST_IDLE) ? dec_kind : pend_kind;
        pulse_start = fire && (fire_kind == ACT_RESET);
    end

    // Sequencer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_kind <= ACT_INJECT;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) pend_kind <= dec_kind;
                    if (fire)          state <= (dec_kind == ACT_RESET) ? ST_RESET : ST_ISSUE;
                    else if (tmr_load) state <= ST_WAIT;
                end
                ST_WAIT:  if (fire)        state <= (pend_kind == ACT_RESET) ? ST_RESET : ST_ISSUE;
                ST_ISSUE: if (insn_accept) state <= ST_IDLE;
                ST_RESET: if (pulse_last)  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Timestamp base: follows accepted packets, cleared by a reset action.
    always_ff @(posedge clk) begin
        if (!rst_n)           base_ts <= '0;
        else if (pulse_start) base_ts <= '0;
        else if (take)        base_ts <= dec_ts;
    end

    // Capture the word and its compressed flag at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            comp_q <= 1'b0;
        end else if (take) begin
            word_q <= dec_insn;
            comp_q <= is_compressed(dec_insn[1:0]);
        end
    end

    // Sticky flag for dropped packets.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cmd_error <= 1'b0;
        else if (accept && dec_kind == ACT_DROP) cmd_error <= 1'b1;
    end

    assign insn_valid      = (state == ST_ISSUE);
    assign insn_word       = word_q;
    assign insn_compressed = comp_q;

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !insn_accept) |=>
            (insn_valid && $stable(insn_word) && $stable(insn_compressed)));

    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (!insn_valid && !dut_reset));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && dec_kind != ACT_DROP) |=> !pkt_ready);

    // R5
    comp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> (insn_compressed == (insn_word[1:0] != 2'b11)));

    // R6
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(insn_valid && dut_reset));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> cmd_error);

    // R8
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && dec_kind == ACT_DROP) |=>
            (cmd_error && pkt_ready && !insn_valid && !dut_reset));
endmodule

// File: tb/inject_sequencer_tb.sv
module inject_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_data = '0;
    logic        pkt_ready;
    logic        insn_valid;
    logic [31:0] insn_word;
    logic        insn_compressed;
    logic        insn_accept = 1'b0;
    logic        dut_reset;
    logic        cmd_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    inject_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_ready(pkt_ready), .insn_valid(insn_valid), .insn_word(insn_word),
        .insn_compressed(insn_compressed), .insn_accept(insn_accept),
        .dut_reset(dut_reset), .cmd_error(cmd_error)
    );

    // Vector table: pad, timestamp, word, expected delay, expected compressed flag.
    localparam int NV = 5;
    localparam logic [7:0]  V_PAD [NV] = '{8'h00, 8'h00, 8'hAB, 8'h5C, 8'h00};
    localparam logic [15:0] V_TS  [NV] = '{16'd3, 16'd3, 16'd10, 16'd4, 16'd6};
    localparam logic [31:0] V_WORD[NV] = '{32'h0050_0093, 32'h0000_4501,
                                           32'hFF00_0013, 32'h0000_8082, 32'h0000_0073};
    localparam int          V_DLY [NV] = '{3, 0, 7, 65530, 2};
    localparam logic        V_CMP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one packet; returns at the first falling edge after acceptance.
    task automatic send(input logic [7:0] pad, input logic [7:0] cmd,
                        input logic [15:0] ts, input logic [31:0] word);
        @(negedge clk);
        pkt_data  = {pad, cmd, ts, word};
        pkt_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    // Count falling edges until the word or the reset pulse shows.
    task automatic wait_event(output int k);
        k = 0;
        while (!insn_valid && !dut_reset && k < 70000) begin
            @(negedge clk);
            k++;
        end
    endtask

    int k;
    int hi;

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(pkt_ready == 1'b1, "R10 ready", pkt_ready, 1);
        chk(insn_valid == 1'b0 && dut_reset == 1'b0, "R10 outputs idle",
            {insn_valid, dut_reset}, 0);
        chk(cmd_error == 1'b0, "R10 error clear", cmd_error, 0);

        // Table walk: inject packets (R1 R3 R4 R5 R9)
        for (int i = 0; i < NV; i++) begin
            send(V_PAD[i], 8'h00, V_TS[i], V_WORD[i]);
            if (V_DLY[i] != 0)
                chk(pkt_ready == 1'b0, "R2 busy after take", pkt_ready, 0);
            wait_event(k);
            chk(k == V_DLY[i], (i == 3) ? "R9 wrapped delay" : "R3 delay", k, V_DLY[i]);
            chk(insn_word == V_WORD[i], "R1 word field", insn_word, V_WORD[i]);
            chk(insn_compressed == V_CMP[i], "R5 compressed flag", insn_compressed, V_CMP[i]);
            @(negedge clk);
            chk(insn_valid && insn_word == V_WORD[i], "R4 held while not accepted",
                insn_word, V_WORD[i]);
            insn_accept = 1'b1;
            @(negedge clk);
            insn_accept = 1'b0;
            chk(!insn_valid && pkt_ready, "R4 release on accept", {insn_valid, pkt_ready}, 1);
        end

        // R8 unknown command dropped, base kept at 6
        send(8'h00, 8'h7E, 16'd100, 32'h1234_5678);
        chk(cmd_error == 1'b1, "R8 error set", cmd_error, 1);
        chk(pkt_ready == 1'b1, "R8 stays ready", pkt_ready, 1);
        repeat (6) @(negedge clk);
        chk(!insn_valid && !dut_reset, "R8 nothing issued", {insn_valid, dut_reset}, 0);
        send(8'h00, 8'h00, 16'd8, 32'h0000_0001);
        wait_event(k);
        chk(k == 2, "R8 base unchanged", k, 2);
        insn_accept = 1'b1;
        @(negedge clk);
        insn_accept = 1'b0;

        // R6 reset command: wait 3, pulse of 4
        send(8'h00, 8'h01, 16'd11, 32'h0);
        wait_event(k);
        chk(k == 3 && dut_reset, "R6 reset delay", k, 3);
        hi = 0;
        while (dut_reset && hi < 20) begin
            chk(!insn_valid, "R6 no issue during reset", insn_valid, 0);
            @(negedge clk);
            hi++;
        end
        chk(hi == 4, "R6 pulse length", hi, 4);
        chk(pkt_ready == 1'b1, "R6 ready after pulse", pkt_ready, 1);
        chk(cmd_error == 1'b1, "R8 error still sticky", cmd_error, 1);

        // R7 base cleared: timestamp 5 waits 5
        send(8'h00, 8'h00, 16'd5, 32'h0000_0002);
        wait_event(k);
        chk(k == 5 && insn_valid, "R7 base cleared", k, 5);
        insn_accept = 1'b1;
        @(negedge clk);
        insn_accept = 1'b0;

        // R10 synchronous reset clears error
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_error == 1'b0 && pkt_ready, "R10 error cleared by reset", cmd_error, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule